// File: doc/BRIEF.md
# Banked Working-Register File with Data Stack

This block holds a small processor's 128-byte internal data RAM and the state that controls how the RAM is reached. The state is an 8-bit status word and an 8-bit stack pointer. The lowest 32 bytes form four banks of eight working registers. Two bank-select bits in the status word choose the active bank. Bytes 20h to 2Fh can also be read and written one bit at a time. Bytes 30h to 7Fh are plain scratch storage. The parity flag in bit 0 of the status word follows the accumulator value at all times. The accumulator enters the block as an input.

A decoder presents one command per cycle on `cmd_valid_i`/`cmd_op_i`. The command arrives together with a register number, a direct byte address, a pointer select, a bit address and write data. The block reaches the RAM in the following ways:
- by working-register number;
- by direct byte address;
- indirectly through R0 or R1 of the active bank;
- by pushing to or popping from the stack through the stack pointer;
- by bit address.

A four-state controller sequences the work:
- **S_IDLE** accepts commands. A command that needs no second step stays in S_IDLE.
- **S_PTR** holds the fetched pointer for an indirect access. An indirect read moves on to S_RESP. An indirect write returns to S_IDLE.
- **S_BITMOD** merges one bit into the byte just read, then returns to S_IDLE.
- **S_RESP** presents read data for one cycle, then returns to S_IDLE.

The named transitions are:
- S_IDLE→S_RESP for register, direct, pop and bit reads;
- S_IDLE→S_PTR for indirect commands;
- S_IDLE→S_BITMOD for bit writes;
- S_PTR→S_RESP for indirect reads;
- S_PTR→S_IDLE for indirect writes;
- S_BITMOD→S_IDLE;
- S_RESP→S_IDLE.

Top module: `banked_regfile`

## Requirements
- R1: After reset the stack pointer is 07h, status bits 7..1 are 0, every RAM byte reads 00h, and `cmd_ready_o` is 1.
- R2: Status bit positions are: 7 carry, 6 auxiliary carry, 5 user flag, 4 bank select high, 3 bank select low, 2 overflow, 1 user bit, 0 parity. Working register n (`reg_num_i`) maps to byte 8×{bit4,bit3}+n. The command codes are: register read 1, register write 2, status write 11 (loads bits 7..1 from `wdata_i[7:1]`).
- R3: Direct read (code 3) and direct write (code 4) reach bytes 00h–7Fh. Every read other than an indirect read shows `rvalid_o`=1 and its data in the cycle after acceptance, with `cmd_ready_o`=0 in that cycle.
- R4: A write to a byte address of 80h or above, whether direct, indirect or by push, changes no RAM byte. A read from such an address returns 00h.
- R5: Indirect read (code 5) and indirect write (code 6) use R0 (`ptr_sel_i`=0) or R1 (`ptr_sel_i`=1) of the active bank as the address. An indirect read delivers data two cycles after acceptance.
- R6: Push (code 7) increments the stack pointer and then writes `wdata_i` at the new value. Pop (code 8) reads at the stack pointer and then decrements it. Stack-pointer write (code 12) loads `wdata_i`. The pointer wraps modulo 256.
- R7: Bit address b selects byte 20h+b/8, bit b mod 8. A bit write (code 10) stores `bit_val_i` there and leaves the other seven bits unchanged. A bit read (code 9) returns the bit in `rdata_o[0]` with bits 7..1 zero.
- R8: `psw_o[0]` is 1 exactly when `acc_i` has an odd number of one bits. It follows `acc_i` in the same cycle, and a status write never changes it.
- R9: A write by any path followed in the next cycle by a read of the same byte by any other path returns the new value.
- R10: A command presented while `cmd_ready_o` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 4 | Command code |
| reg_num_i | input | 3 | Working-register number |
| ptr_sel_i | input | 1 | Indirect pointer select: 0 = R0, 1 = R1 |
| dir_addr_i | input | 8 | Direct byte address |
| bit_addr_i | input | 7 | Bit address |
| bit_val_i | input | 1 | Value for a bit write |
| wdata_i | input | 8 | Write, push, status or stack-pointer data |
| acc_i | input | 8 | Accumulator value |
| cmd_ready_o | output | 1 | Controller idle and able to accept a command |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 8 | Read data |
| psw_o | output | 8 | Status word, with live parity in bit 0 |
| sp_o | output | 8 | Stack pointer |

## Verification
The bench writes one byte through each path and reads it back through another path in the very next cycle, under every bank select. A wrong bank mapping or a stale read shows up there as the wrong byte. It pushes to the stack at 7Fh and FFh and points an indirect write above 7Fh. A design that dropped the top address bit would overwrite a low byte, and the bench catches that by reading the low alias afterwards. Bit writes go into bytes that already hold other set bits, so a design that wrote the whole byte would clear its neighbours. A write command held on the bus while the controller is busy must leave the target byte unchanged, and the parity bit must ignore a status write that sets bit 0.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_RD_REG = 4'd1,
        OP_WR_REG = 4'd2,
        OP_RD_DIR = 4'd3,
        OP_WR_DIR = 4'd4,
        OP_RD_IND = 4'd5,
        OP_WR_IND = 4'd6,
        OP_PUSH   = 4'd7,
        OP_POP    = 4'd8,
        OP_BIT_RD = 4'd9,
        OP_BIT_WR = 4'd10,
        OP_PSW_WR = 4'd11,
        OP_SP_WR  = 4'd12
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PTR,
        S_BITMOD,
        S_RESP
    } state_e;

    // status word positions of the bank-select pair
    localparam int PSW_BANK_HI = 4;
    localparam int PSW_BANK_LO = 3;

endpackage

// File: rtl/rbf_ram.sv
module rbf_ram #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (we && (waddr == AW'(i))) begin
                mem[i] <= wdata;
            end
        end
    end

    // registered read, returns the stored value before any same-edge write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/rbf_addr_map.sv
module rbf_addr_map #(
    parameter int RAM_AW   = 7,
    parameter int BANK_W   = 2,
    parameter int REG_W    = 3,
    parameter int BIT_AW   = 7,
    parameter int BIT_BASE = 32
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [REG_W-1:0]  reg_num,
    input  logic              ptr_sel,
    input  logic [BIT_AW-1:0] bit_addr,
    output logic [RAM_AW-1:0] reg_idx,
    output logic [RAM_AW-1:0] ptr_idx,
    output logic [RAM_AW-1:0] bit_idx,
    output logic [2:0]        bit_pos
);

    localparam logic [RAM_AW-1:0] BIT_BASE_IDX = RAM_AW'(BIT_BASE);

    // a bank of 2**REG_W registers starts at bank * 2**REG_W
    assign reg_idx = RAM_AW'({bank, reg_num});
    assign ptr_idx = RAM_AW'({bank, {(REG_W-1){1'b0}}, ptr_sel});
    assign bit_idx = BIT_BASE_IDX + RAM_AW'(bit_addr[BIT_AW-1:3]);
    assign bit_pos = bit_addr[2:0];

endmodule

// File: rtl/rbf_ctrl.sv
module rbf_ctrl
    import rbf_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int RAM_BYTES = 128,
    parameter int RAM_AW    = $clog2(RAM_BYTES),
    parameter int BANK_W    = 2,
    parameter int SP_INIT   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic [RAM_AW-1:0] reg_idx,
    input  logic [RAM_AW-1:0] ptr_idx,
    input  logic [RAM_AW-1:0] bit_idx,
    input  logic [2:0]        bit_pos,
    input  logic              bit_val,
    input  logic [7:0]        ram_q,
    output logic [RAM_AW-1:0] ram_raddr,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_waddr,
    output logic [7:0]        ram_wdata,
    output logic [BANK_W-1:0] bank,
    output logic [6:0]        flags,
    output logic [ADDR_W-1:0] sp,
    output logic              cmd_ready,
    output logic              rvalid,
    output logic [7:0]        rdata
);

    localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_BYTES - 1);
    localparam logic [ADDR_W-1:0] SP_RST   = ADDR_W'(SP_INIT);

    state_e            state_q, state_d;
    logic [ADDR_W-1:0] sp_q, sp_d;
    logic [6:0]        flags_q, flags_d;
    logic              ind_wr_q, ind_wr_d;
    logic [7:0]        hold_data_q, hold_data_d;
    logic [RAM_AW-1:0] hold_idx_q, hold_idx_d;
    logic [2:0]        hold_pos_q, hold_pos_d;
    logic              hold_bit_q, hold_bit_d;
    logic              resp_bit_q, resp_bit_d;
    logic              resp_zero_q, resp_zero_d;

    op_e               op;
    logic              accept;
    logic [ADDR_W-1:0] sp_inc;
    logic [ADDR_W-1:0] ptr_val;
    logic [7:0]        merged;

    assign op      = op_e'(cmd_op);
    assign accept  = cmd_valid && (state_q == S_IDLE);
    assign sp_inc  = sp_q + 1'b1;
    assign ptr_val = ADDR_W'(ram_q);

    always_comb begin
        merged = ram_q;
        merged[hold_pos_q] = hold_bit_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            sp_q        <= SP_RST;
            flags_q     <= '0;
            ind_wr_q    <= 1'b0;
            hold_data_q <= '0;
            hold_idx_q  <= '0;
            hold_pos_q  <= '0;
            hold_bit_q  <= 1'b0;
            resp_bit_q  <= 1'b0;
            resp_zero_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            sp_q        <= sp_d;
            flags_q     <= flags_d;
            ind_wr_q    <= ind_wr_d;
            hold_data_q <= hold_data_d;
            hold_idx_q  <= hold_idx_d;
            hold_pos_q  <= hold_pos_d;
            hold_bit_q  <= hold_bit_d;
            resp_bit_q  <= resp_bit_d;
            resp_zero_q <= resp_zero_d;
        end
    end

    // next state and RAM port control
    always_comb begin
        state_d     = state_q;
        sp_d        = sp_q;
        flags_d     = flags_q;
        ind_wr_d    = ind_wr_q;
        hold_data_d = hold_data_q;
        hold_idx_d  = hold_idx_q;
        hold_pos_d  = hold_pos_q;
        hold_bit_d  = hold_bit_q;
        resp_bit_d  = resp_bit_q;
        resp_zero_d = resp_zero_q;
        ram_raddr   = hold_idx_q;
        ram_we      = 1'b0;
        ram_waddr   = hold_idx_q;
        ram_wdata   = wdata;

        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    resp_bit_d  = 1'b0;
                    resp_zero_d = 1'b0;
                    unique case (op)
                        OP_RD_REG: begin
                            ram_raddr = reg_idx;
                            state_d   = S_RESP;
                        end
                        OP_WR_REG: begin
                            ram_we    = 1'b1;
                            ram_waddr = reg_idx;
                        end
                        OP_RD_DIR: begin
                            ram_raddr   = dir_addr[RAM_AW-1:0];
                            resp_zero_d = (dir_addr > RAM_LAST);
                            state_d     = S_RESP;
                        end
                        OP_WR_DIR: begin
                            ram_we    = (dir_addr <= RAM_LAST);
                            ram_waddr = dir_addr[RAM_AW-1:0];
                        end
                        OP_RD_IND, OP_WR_IND: begin
                            ram_raddr   = ptr_idx;
                            ind_wr_d    = (op == OP_WR_IND);
                            hold_data_d = wdata;
                            state_d     = S_PTR;
                        end
                        OP_PUSH: begin
                            sp_d      = sp_inc;
                            ram_we    = (sp_inc <= RAM_LAST);
                            ram_waddr = sp_inc[RAM_AW-1:0];
                        end
                        OP_POP: begin
                            ram_raddr   = sp_q[RAM_AW-1:0];
                            resp_zero_d = (sp_q > RAM_LAST);
                            sp_d        = sp_q - 1'b1;
                            state_d     = S_RESP;
                        end
                        OP_BIT_RD: begin
                            ram_raddr  = bit_idx;
                            resp_bit_d = 1'b1;
                            hold_pos_d = bit_pos;
                            state_d    = S_RESP;
                        end
                        OP_BIT_WR: begin
                            ram_raddr  = bit_idx;
                            hold_idx_d = bit_idx;
                            hold_pos_d = bit_pos;
                            hold_bit_d = bit_val;
                            state_d    = S_BITMOD;
                        end
                        OP_PSW_WR: flags_d = wdata[7:1];
                        OP_SP_WR:  sp_d    = ADDR_W'(wdata);
                        default: ;
                    endcase
                end
            end
            S_PTR: begin
                if (ind_wr_q) begin
                    ram_we    = (ptr_val <= RAM_LAST);
                    ram_waddr = ptr_val[RAM_AW-1:0];
                    ram_wdata = hold_data_q;
                    state_d   = S_IDLE;
                end else begin
                    ram_raddr   = ptr_val[RAM_AW-1:0];
                    resp_zero_d = (ptr_val > RAM_LAST);
                    state_d     = S_RESP;
                end
            end
            S_BITMOD: begin
                ram_we    = 1'b1;
                ram_waddr = hold_idx_q;
                ram_wdata = merged;
                state_d   = S_IDLE;
            end
            S_RESP: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready = (state_q == S_IDLE);
        rvalid    = (state_q == S_RESP);
        if (resp_zero_q) begin
            rdata = '0;
        end else if (resp_bit_q) begin
            rdata = {7'b0, ram_q[hold_pos_q]};
        end else begin
            rdata = ram_q;
        end
    end

    assign sp    = sp_q;
    assign flags = flags_q;
    assign bank  = flags_q[PSW_BANK_HI-1:PSW_BANK_LO-1];

    // R6: push moves the pointer up by one
    a_r6_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_PUSH) |=> (sp_q == ADDR_W'($past(sp_q) + 1'b1)));

    // R6: pop moves the pointer down by one
    a_r6_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_POP) |=> (sp_q == ADDR_W'($past(sp_q) - 1'b1)));

    // R3: single-step reads answer in the next cycle while busy
    a_r3_read_next: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op == OP_RD_REG || op == OP_RD_DIR || op == OP_POP || op == OP_BIT_RD))
        |=> (rvalid && !cmd_ready));

    // R5: an indirect read answers after the pointer step
    a_r5_ind_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PTR && !ind_wr_q) |=> rvalid);

    // R4: an out-of-range direct write or push never reaches the RAM
    a_r4_no_high_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((accept && op == OP_WR_DIR && dir_addr > RAM_LAST) ||
         (accept && op == OP_PUSH && sp_inc > RAM_LAST)) |-> !ram_we);

    // R7: the merge step flips at most one bit of the stored byte
    a_r7_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BITMOD) |-> ($countones(ram_wdata ^ ram_q) <= 1));

    // R10: a busy cycle leaves pointer and flags untouched
    a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> ($stable(sp_q) && $stable(flags_q)));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
    parameter int RAM_BYTES = 128,
    parameter int N_BANKS   = 4,
    parameter int BANK_REGS = 8,
    parameter int BIT_COUNT = 128,
    parameter int BIT_BASE  = 32,
    parameter int SP_INIT   = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid_i,
    input  logic [3:0] cmd_op_i,
    input  logic [2:0] reg_num_i,
    input  logic       ptr_sel_i,
    input  logic [7:0] dir_addr_i,
    input  logic [6:0] bit_addr_i,
    input  logic       bit_val_i,
    input  logic [7:0] wdata_i,
    input  logic [7:0] acc_i,
    output logic       cmd_ready_o,
    output logic       rvalid_o,
    output logic [7:0] rdata_o,
    output logic [7:0] psw_o,
    output logic [7:0] sp_o
);

    localparam int RAM_AW = $clog2(RAM_BYTES);
    localparam int BANK_W = $clog2(N_BANKS);
    localparam int REG_W  = $clog2(BANK_REGS);
    localparam int BIT_AW = $clog2(BIT_COUNT);

    logic [RAM_AW-1:0] reg_idx, ptr_idx, bit_idx;
    logic [2:0]        bit_pos;
    logic [RAM_AW-1:0] ram_raddr, ram_waddr;
    logic              ram_we;
    logic [7:0]        ram_wdata, ram_q;
    logic [BANK_W-1:0] bank;
    logic [6:0]        flags;

    rbf_addr_map #(
        .RAM_AW  (RAM_AW),
        .BANK_W  (BANK_W),
        .REG_W   (REG_W),
        .BIT_AW  (BIT_AW),
        .BIT_BASE(BIT_BASE)
    ) u_map (
        .bank    (bank),
        .reg_num (reg_num_i[REG_W-1:0]),
        .ptr_sel (ptr_sel_i),
        .bit_addr(bit_addr_i[BIT_AW-1:0]),
        .reg_idx (reg_idx),
        .ptr_idx (ptr_idx),
        .bit_idx (bit_idx),
        .bit_pos (bit_pos)
    );

    rbf_ctrl #(
        .ADDR_W   (8),
        .RAM_BYTES(RAM_BYTES),
        .RAM_AW   (RAM_AW),
        .BANK_W   (BANK_W),
        .SP_INIT  (SP_INIT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid_i),
        .cmd_op   (cmd_op_i),
        .wdata    (wdata_i),
        .dir_addr (dir_addr_i),
        .reg_idx  (reg_idx),
        .ptr_idx  (ptr_idx),
        .bit_idx  (bit_idx),
        .bit_pos  (bit_pos),
        .bit_val  (bit_val_i),
        .ram_q    (ram_q),
        .ram_raddr(ram_raddr),
        .ram_we   (ram_we),
        .ram_waddr(ram_waddr),
        .ram_wdata(ram_wdata),
        .bank     (bank),
        .flags    (flags),
        .sp       (sp_o),
        .cmd_ready(cmd_ready_o),
        .rvalid   (rvalid_o),
        .rdata    (rdata_o)
    );

    rbf_ram #(
        .DEPTH(RAM_BYTES),
        .DW   (8),
        .AW   (RAM_AW)
    ) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(ram_wdata),
        .raddr(ram_raddr),
        .rdata(ram_q)
    );

    // parity is recomputed from the accumulator every cycle
    assign psw_o = {flags, ^acc_i};

endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] C_RD_REG = 4'd1, C_WR_REG = 4'd2, C_RD_DIR = 4'd3,
                           C_WR_DIR = 4'd4, C_RD_IND = 4'd5, C_WR_IND = 4'd6,
                           C_PUSH = 4'd7, C_POP = 4'd8, C_BIT_RD = 4'd9,
                           C_BIT_WR = 4'd10, C_PSW_WR = 4'd11, C_SP_WR = 4'd12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [2:0] reg_num = '0;
    logic       ptr_sel = 1'b0;
    logic [7:0] dir_addr = '0;
    logic [6:0] bit_addr = '0;
    logic       bit_val = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] acc = '0;
    logic       cmd_ready, rvalid;
    logic [7:0] rdata, psw, sp;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] rv;
    int rl;

    banked_regfile u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .reg_num_i(reg_num), .ptr_sel_i(ptr_sel), .dir_addr_i(dir_addr),
        .bit_addr_i(bit_addr), .bit_val_i(bit_val), .wdata_i(wdata), .acc_i(acc),
        .cmd_ready_o(cmd_ready), .rvalid_o(rvalid), .rdata_o(rdata),
        .psw_o(psw), .sp_o(sp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // called at a falling edge with the controller idle
    task automatic issue(input logic [3:0] op, input logic [2:0] rn, input logic ps,
                         input logic [7:0] da, input logic [6:0] ba, input logic bv,
                         input logic [7:0] wd);
        rv = '0;
        rl = 0;
        cmd_op = op; reg_num = rn; ptr_sel = ps; dir_addr = da;
        bit_addr = ba; bit_val = bv; wdata = wd; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int c = 1; c <= 6; c++) begin
            if (rvalid && rl == 0) begin
                rv = rdata;
                rl = c;
            end
            if (cmd_ready) break;
            @(negedge clk);
        end
    endtask

    task automatic wr_dir(input logic [7:0] a, input logic [7:0] d); issue(C_WR_DIR, 0, 0, a, 0, 0, d); endtask
    task automatic rd_dir(input logic [7:0] a); issue(C_RD_DIR, 0, 0, a, 0, 0, 0); endtask
    task automatic wr_reg(input logic [2:0] n, input logic [7:0] d); issue(C_WR_REG, n, 0, 0, 0, 0, d); endtask
    task automatic rd_reg(input logic [2:0] n); issue(C_RD_REG, n, 0, 0, 0, 0, 0); endtask
    task automatic wr_ind(input logic p, input logic [7:0] d); issue(C_WR_IND, 0, p, 0, 0, 0, d); endtask
    task automatic rd_ind(input logic p); issue(C_RD_IND, 0, p, 0, 0, 0, 0); endtask
    task automatic push(input logic [7:0] d); issue(C_PUSH, 0, 0, 0, 0, 0, d); endtask
    task automatic pop(); issue(C_POP, 0, 0, 0, 0, 0, 0); endtask
    task automatic bit_wr(input logic [6:0] b, input logic v); issue(C_BIT_WR, 0, 0, 0, b, v, 0); endtask
    task automatic bit_rd(input logic [6:0] b); issue(C_BIT_RD, 0, 0, 0, b, 0, 0); endtask
    task automatic psw_wr(input logic [7:0] d); issue(C_PSW_WR, 0, 0, 0, 0, 0, d); endtask
    task automatic sp_wr(input logic [7:0] d); issue(C_SP_WR, 0, 0, 0, 0, 0, d); endtask

    task automatic t_reset();
        chk("R1", "sp", sp, 8'h07);
        chk("R1", "psw", psw, 8'h00);
        chk("R1", "ready", {7'b0, cmd_ready}, 8'h01);
        rd_dir(8'h45); chk("R1", "ram 45", rv, 8'h00);
        rd_dir(8'h7F); chk("R1", "ram 7f", rv, 8'h00);
    endtask

    task automatic t_banks();
        for (int b = 0; b < 4; b++) begin
            psw_wr(8'(b << 3));
            chk("R2", "bank bits", psw & 8'h18, 8'(b << 3));
            wr_reg(3'd5, 8'(8'hA0 + b));
            rd_dir(8'(8 * b + 5));
            chk("R2", "reg5 via direct", rv, 8'(8'hA0 + b));
        end
        psw_wr(8'h10);
        wr_dir(8'h13, 8'h4E);
        rd_reg(3'd3);
        chk("R2", "bank2 r3", rv, 8'h4E);
        psw_wr(8'h00);
    endtask

    task automatic t_direct();
        wr_dir(8'h30, 8'h5A);
        rd_dir(8'h30);
        chk("R3", "data 30", rv, 8'h5A);
        chk("R3", "latency", 8'(rl), 8'd1);
    endtask

    task automatic t_high();
        wr_dir(8'h10, 8'h3C);
        wr_dir(8'h90, 8'h77);
        rd_dir(8'h90); chk("R4", "read 90", rv, 8'h00);
        rd_dir(8'h10); chk("R4", "alias 10 kept", rv, 8'h3C);
    endtask

    task automatic t_indirect();
        psw_wr(8'h08);
        wr_reg(3'd0, 8'h40);
        wr_reg(3'd1, 8'h41);
        wr_ind(1'b1, 8'hC3);
        rd_dir(8'h41); chk("R5", "via R1 write", rv, 8'hC3);
        wr_dir(8'h40, 8'h3C);
        rd_ind(1'b0);
        chk("R5", "via R0 read", rv, 8'h3C);
        chk("R5", "latency", 8'(rl), 8'd2);
        wr_dir(8'h05, 8'h66);
        wr_reg(3'd0, 8'h85);
        wr_ind(1'b0, 8'hEE);
        rd_ind(1'b0); chk("R4", "indirect high read", rv, 8'h00);
        rd_dir(8'h05); chk("R4", "indirect alias kept", rv, 8'h66);
        psw_wr(8'h00);
    endtask

    task automatic t_stack();
        push(8'h11); chk("R6", "sp after push", sp, 8'h08);
        rd_dir(8'h08); chk("R6", "pushed byte", rv, 8'h11);
        push(8'h22); chk("R6", "sp after 2nd push", sp, 8'h09);
        pop(); chk("R6", "pop data", rv, 8'h22); chk("R6", "sp after pop", sp, 8'h08);
        pop(); chk("R6", "pop data 2", rv, 8'h11); chk("R6", "sp back", sp, 8'h07);
        sp_wr(8'hFF);
        push(8'h99); chk("R6", "sp wrap up", sp, 8'h00);
        rd_dir(8'h00); chk("R6", "wrap byte", rv, 8'h99);
        pop(); chk("R6", "wrap pop", rv, 8'h99); chk("R6", "sp wrap down", sp, 8'hFF);
        sp_wr(8'h7F);
        push(8'h55); chk("R6", "sp to 80", sp, 8'h80);
        rd_dir(8'h00); chk("R4", "push alias kept", rv, 8'h99);
        pop(); chk("R4", "pop high", rv, 8'h00); chk("R6", "sp 7f", sp, 8'h7F);
        sp_wr(8'h07);
    endtask

    task automatic t_bits();
        wr_dir(8'h25, 8'h00);
        bit_wr(7'd43, 1'b1); rd_dir(8'h25); chk("R7", "set bit3", rv, 8'h08);
        bit_wr(7'd45, 1'b1); rd_dir(8'h25); chk("R7", "set bit5", rv, 8'h28);
        bit_wr(7'd43, 1'b0); rd_dir(8'h25); chk("R7", "clear bit3", rv, 8'h20);
        bit_rd(7'd45); chk("R7", "read bit5", rv, 8'h01);
        bit_rd(7'd43); chk("R7", "read bit3", rv, 8'h00);
        wr_dir(8'h2F, 8'h7F);
        bit_wr(7'd127, 1'b1); rd_dir(8'h2F); chk("R7", "bit127", rv, 8'hFF);
    endtask

    task automatic t_parity();
        acc = 8'h01; #1; chk("R8", "acc 01", {7'b0, psw[0]}, 8'h01);
        acc = 8'h03; #1; chk("R8", "acc 03", {7'b0, psw[0]}, 8'h00);
        acc = 8'hFE; #1; chk("R8", "acc fe", {7'b0, psw[0]}, 8'h01);
        acc = 8'h03;
        @(negedge clk);
        psw_wr(8'hFF);
        chk("R8", "status write", psw, 8'hFE);
        psw_wr(8'h00);
        acc = 8'h00;
    endtask

    task automatic t_consistency();
        psw_wr(8'h18);
        wr_dir(8'h1A, 8'h6D);
        rd_reg(3'd2); chk("R9", "direct then reg", rv, 8'h6D);
        wr_reg(3'd0, 8'h1B);
        wr_reg(3'd3, 8'h12);
        rd_ind(1'b0); chk("R9", "reg then indirect", rv, 8'h12);
        wr_ind(1'b0, 8'hA5);
        rd_reg(3'd3); chk("R9", "indirect then reg", rv, 8'hA5);
        psw_wr(8'h00);
    endtask

    task automatic t_busy();
        cmd_op = C_RD_DIR; dir_addr = 8'h30; cmd_valid = 1'b1;
        @(negedge clk);
        chk("R10", "ready low", {7'b0, cmd_ready}, 8'h00);
        cmd_op = C_WR_DIR; dir_addr = 8'h30; wdata = 8'hFF;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        rd_dir(8'h30); chk("R10", "busy write ignored", rv, 8'h5A);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_banks();
        t_direct();
        t_high();
        t_indirect();
        t_stack();
        t_bits();
        t_parity();
        t_consistency();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule